// File: doc/BRIEF.md
# Masked Acquisition Compare Engine

This block checks a captured trace against a stored reference, after the capture has finished. The trace sits in an external acquisition RAM, which the engine reads through a synchronous port. The reference sits in an image RAM inside the engine. A copy command fills the image from the acquisition one row per clock. After that, single bits of any image row can be rewritten through an edit port while the engine is idle.

A compare command reads acquisition and image rows in step, one row per clock, over an inclusive row window. It XORs each pair of words and masks the result with a channel-enable word. For each row it reports whether any enabled bit differs. When the walk ends it pulses done and presents an overall equal or not-equal result. In repeat mode it also raises a stop request when that result matches the selected stop condition. The reference occupies half of the capture memory, so both RAMs are `MEM_ROWS/2` rows deep.

Top module: `acq_compare_engine`

## Requirements
- R1: A `copy_start` sampled while idle copies every image row 0 to `MEM_ROWS/2-1` from the acquisition RAM. `done` is high for one cycle after the (`MEM_ROWS/2`+1)th rising edge that follows the edge which sampled the start. A following full-range, full-mask compare then reports equal.
- R2: An edit write sampled while idle changes only the bits of image row `edit_row` whose `edit_bit_en` bit is 1, setting them to `edit_value`. An edit write sampled while `busy` is 1 has no effect.
- R3: An image bit whose position holds 0 in `cfg_chan_mask` never causes a row difference.
- R4: A compare reads only rows `cfg_row_first` to `cfg_row_last` inclusive, in ascending order. It reports them on `diff_valid`/`diff_row`, one row per cycle.
- R5: With `diff_valid` = 1, `diff_flag` is 1 exactly when the row has at least one enabled bit that differs.
- R6: For a range of N rows, `done` is high for one cycle after the (N+1)th rising edge following the start edge. `result_equal` is 1 at that point exactly when no row in range differed.
- R7: A range with `cfg_row_first` greater than `cfg_row_last` reads no row. It gives `done` after the first edge following the start edge, with `result_equal` = 1.
- R8: `stop_req` pulses together with `done` only when `cfg_repeat` = 1 and the result matches `cfg_stop_on_equal`: equal when it is 1, not equal when it is 0.
- R9: A start command sampled while `busy` is 1 is ignored. The range, mask and mode taken at the accepted start stay in force until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| copy_start | input | 1 | Copy acquisition into image (wins over compare) |
| cmp_start | input | 1 | Start a compare |
| cfg_chan_mask | input | WIDTH | Channel enable, 1 = compared |
| cfg_row_first | input | AW | First row of window |
| cfg_row_last | input | AW | Last row of window |
| cfg_repeat | input | 1 | Repeat mode, enables stop request |
| cfg_stop_on_equal | input | 1 | 1: stop on equal, 0: stop on differ |
| edit_wr_en | input | 1 | Image bit edit strobe |
| edit_row | input | AW | Row to edit |
| edit_value | input | WIDTH | New bit values |
| edit_bit_en | input | WIDTH | Bits to overwrite |
| acq_rd_en | output | 1 | Acquisition RAM read enable |
| acq_rd_addr | output | AW | Acquisition RAM read row |
| acq_rd_data | input | WIDTH | Acquisition word, one cycle after read |
| busy | output | 1 | Copy or compare in progress |
| done | output | 1 | One-cycle end pulse |
| result_equal | output | 1 | Overall result of last compare |
| diff_valid | output | 1 | Row report valid |
| diff_row | output | AW | Reported row |
| diff_flag | output | 1 | Row has an enabled difference |
| stop_req | output | 1 | Repeat-run stop request |

## Verification
The hardest case to set up is a start or an edit that arrives in the middle of a walk while the configuration pins are changing. The bench pokes `cmp_start`, a new range and a full-row edit write partway through a compare. It then checks that exactly one `done` follows and that the row reports still follow the original window. A later single-row compare shows that the edited row kept its copied contents. Mixed mask and range vectors place a known difference just inside, just outside or hidden under the mask.

// File: rtl/acq_cmp_pkg.sv
package acq_cmp_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_WALK  = 2'd1,
      SEQ_DRAIN = 2'd2
   } seq_state_t;
endpackage

// File: rtl/acq_cmp_image_ram.sv
module acq_cmp_image_ram #(
   parameter int WIDTH = 16,
   parameter int ROWS  = 32,
   parameter int AW    = 5
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [WIDTH-1:0] wr_bits,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);
   // one storage column per channel so each bit is independently writable
   for (genvar b = 0; b < WIDTH; b++) begin : gen_lane
      logic [ROWS-1:0] lane_q;
      logic            rd_q;
      always_ff @(posedge clk) begin
         if (wr_en && wr_bits[b]) lane_q[wr_addr] <= wr_data[b];
         if (rd_en) rd_q <= lane_q[rd_addr];
      end
      assign rd_data[b] = rd_q;
   end
endmodule

// File: rtl/acq_cmp_sequencer.sv
module acq_cmp_sequencer import acq_cmp_pkg::*; #(
   parameter int AW       = 5,
   parameter int LAST_ROW = 31
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          copy_req,
   input  logic          cmp_req,
   input  logic [AW-1:0] first_row,
   input  logic [AW-1:0] last_row,
   output logic          busy,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   output logic          pipe_vld,
   output logic [AW-1:0] pipe_row,
   output logic          copy_mode,
   output logic          draining,
   output logic          finish
);
   localparam logic [AW-1:0] LAST = AW'(LAST_ROW);

   seq_state_t    state_q;
   logic [AW-1:0] addr_q, hi_q;
   logic          copy_q, vld_q, fin_q;
   logic [AW-1:0] row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         addr_q  <= '0;
         hi_q    <= '0;
         copy_q  <= 1'b0;
         vld_q   <= 1'b0;
         row_q   <= '0;
         fin_q   <= 1'b0;
      end else begin
         vld_q <= (state_q == SEQ_WALK);
         row_q <= addr_q;
         fin_q <= (state_q == SEQ_DRAIN);
         unique case (state_q)
            SEQ_IDLE: begin
               if (copy_req) begin
                  copy_q  <= 1'b1;
                  addr_q  <= '0;
                  hi_q    <= LAST;
                  state_q <= SEQ_WALK;
               end else if (cmp_req) begin
                  copy_q  <= 1'b0;
                  addr_q  <= first_row;
                  hi_q    <= last_row;
                  state_q <= (first_row > last_row) ? SEQ_DRAIN : SEQ_WALK;
               end
            end
            SEQ_WALK: begin
               if (addr_q == hi_q) state_q <= SEQ_DRAIN;
               else addr_q <= addr_q + 1'b1;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != SEQ_IDLE);
   assign rd_en     = (state_q == SEQ_WALK);
   assign rd_addr   = addr_q;
   assign pipe_vld  = vld_q;
   assign pipe_row  = row_q;
   assign copy_mode = copy_q;
   assign draining  = (state_q == SEQ_DRAIN);
   assign finish    = fin_q;

   assert_walk_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_WALK) && $past(state_q == SEQ_WALK) |-> addr_q == $past(addr_q) + 1'b1);
   assert_window_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SEQ_IDLE) && $past(state_q != SEQ_IDLE) |-> $stable(hi_q) && $stable(copy_q));
endmodule

// File: rtl/acq_cmp_row_checker.sv
module acq_cmp_row_checker #(
   parameter int WIDTH = 16,
   parameter int AW    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             vld,
   input  logic [AW-1:0]    row,
   input  logic [WIDTH-1:0] acq_word,
   input  logic [WIDTH-1:0] img_word,
   input  logic [WIDTH-1:0] mask,
   input  logic             last,
   input  logic             repeat_mode,
   input  logic             stop_on_eq,
   output logic             diff_valid,
   output logic [AW-1:0]    diff_row,
   output logic             diff_flag,
   output logic             not_equal,
   output logic             stop_req
);
   logic [WIDTH-1:0] masked;
   logic             row_hit, neq_next;
   logic             dv_q, df_q, neq_q, stop_q;
   logic [AW-1:0]    dr_q;

   assign masked   = (acq_word ^ img_word) & mask;
   assign row_hit  = |masked;
   assign neq_next = neq_q | (vld & row_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dv_q   <= 1'b0;
         df_q   <= 1'b0;
         dr_q   <= '0;
         neq_q  <= 1'b0;
         stop_q <= 1'b0;
      end else begin
         dv_q   <= vld;
         df_q   <= vld & row_hit;
         dr_q   <= row;
         neq_q  <= clear ? 1'b0 : neq_next;
         stop_q <= last & repeat_mode & (stop_on_eq ? ~neq_next : neq_next);
      end
   end

   assign diff_valid = dv_q;
   assign diff_row   = dr_q;
   assign diff_flag  = df_q;
   assign not_equal  = neq_q;
   assign stop_req   = stop_q;

   assert_flag_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      diff_flag |-> not_equal);
   assert_flag_in_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
      diff_flag |-> diff_valid);
endmodule

// File: rtl/acq_compare_engine.sv
module acq_compare_engine #(
   parameter int WIDTH    = 16,
   parameter int MEM_ROWS = 64,
   parameter int AW       = $clog2(MEM_ROWS / 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             copy_start,
   input  logic             cmp_start,
   input  logic [WIDTH-1:0] cfg_chan_mask,
   input  logic [AW-1:0]    cfg_row_first,
   input  logic [AW-1:0]    cfg_row_last,
   input  logic             cfg_repeat,
   input  logic             cfg_stop_on_equal,
   input  logic             edit_wr_en,
   input  logic [AW-1:0]    edit_row,
   input  logic [WIDTH-1:0] edit_value,
   input  logic [WIDTH-1:0] edit_bit_en,
   output logic             acq_rd_en,
   output logic [AW-1:0]    acq_rd_addr,
   input  logic [WIDTH-1:0] acq_rd_data,
   output logic             busy,
   output logic             done,
   output logic             result_equal,
   output logic             diff_valid,
   output logic [AW-1:0]    diff_row,
   output logic             diff_flag,
   output logic             stop_req
);
   // half of the capture memory holds the reference image
   localparam int IMG_ROWS = MEM_ROWS / 2;

   if (MEM_ROWS % 2 != 0 || (1 << AW) != IMG_ROWS) begin : gen_bad_depth
      $error("MEM_ROWS must be twice a power of two matching AW");
   end
   if (WIDTH < 1) begin : gen_bad_width
      $error("WIDTH must be at least 1");
   end

   logic             seq_busy, rd_en, pipe_vld, copy_mode, draining, finish;
   logic [AW-1:0]    rd_addr, pipe_row;
   logic             cmp_go, copy_wr, img_wr_en, not_equal;
   logic [AW-1:0]    img_wr_addr;
   logic [WIDTH-1:0] img_wr_data, img_wr_bits, img_rd_data;
   logic [WIDTH-1:0] mask_q;
   logic             rep_q, steq_q;

   acq_cmp_sequencer #(.AW(AW), .LAST_ROW(IMG_ROWS - 1)) u_seq (
      .clk(clk), .rst_n(rst_n), .copy_req(copy_start), .cmp_req(cmp_start),
      .first_row(cfg_row_first), .last_row(cfg_row_last), .busy(seq_busy),
      .rd_en(rd_en), .rd_addr(rd_addr), .pipe_vld(pipe_vld), .pipe_row(pipe_row),
      .copy_mode(copy_mode), .draining(draining), .finish(finish)
   );

   // compare configuration is captured once per accepted start
   assign cmp_go = cmp_start & ~seq_busy & ~copy_start;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         rep_q  <= 1'b0;
         steq_q <= 1'b0;
      end else if (cmp_go) begin
         mask_q <= cfg_chan_mask;
         rep_q  <= cfg_repeat;
         steq_q <= cfg_stop_on_equal;
      end
   end

   assign copy_wr     = pipe_vld & copy_mode;
   assign img_wr_en   = copy_wr | (edit_wr_en & ~seq_busy);
   assign img_wr_addr = copy_wr ? pipe_row : edit_row;
   assign img_wr_data = copy_wr ? acq_rd_data : edit_value;
   assign img_wr_bits = copy_wr ? {WIDTH{1'b1}} : edit_bit_en;

   acq_cmp_image_ram #(.WIDTH(WIDTH), .ROWS(IMG_ROWS), .AW(AW)) u_img (
      .clk(clk), .wr_en(img_wr_en), .wr_addr(img_wr_addr), .wr_data(img_wr_data),
      .wr_bits(img_wr_bits), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(img_rd_data)
   );

   acq_cmp_row_checker #(.WIDTH(WIDTH), .AW(AW)) u_chk (
      .clk(clk), .rst_n(rst_n), .clear(cmp_go), .vld(pipe_vld & ~copy_mode),
      .row(pipe_row), .acq_word(acq_rd_data), .img_word(img_rd_data), .mask(mask_q),
      .last(draining & ~copy_mode), .repeat_mode(rep_q), .stop_on_eq(steq_q),
      .diff_valid(diff_valid), .diff_row(diff_row), .diff_flag(diff_flag),
      .not_equal(not_equal), .stop_req(stop_req)
   );

   assign acq_rd_en    = rd_en;
   assign acq_rd_addr  = rd_addr;
   assign busy         = seq_busy;
   assign done         = finish;
   assign result_equal = ~not_equal;

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_stop_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |-> done);
   assert_edit_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !(pipe_vld && copy_mode) |-> !img_wr_en);
endmodule

// File: tb/tb_acq_compare_engine.sv
module tb_acq_compare_engine;
   localparam int W    = 16;
   localparam int ROWS = 32;
   localparam int AW   = 5;

   typedef struct packed {
      logic [W-1:0]  mask;
      logic [AW-1:0] lo;
      logic [AW-1:0] hi;
      logic          rep;
      logic          steq;
      logic          exp_eq;
      logic          exp_stop;
   } vec_t;

   // image differs from acquisition at row 5 bit 3 and row 20 bits 15:12
   localparam vec_t VECS [0:11] = '{
      '{16'hFFFF, 5'd0,  5'd31, 1'b0, 1'b0, 1'b0, 1'b0},
      '{16'h0FF7, 5'd0,  5'd31, 1'b0, 1'b0, 1'b1, 1'b0},
      '{16'hFFFF, 5'd6,  5'd19, 1'b0, 1'b0, 1'b1, 1'b0},
      '{16'hFFFF, 5'd5,  5'd5,  1'b0, 1'b0, 1'b0, 1'b0},
      '{16'h0008, 5'd0,  5'd31, 1'b0, 1'b0, 1'b0, 1'b0},
      '{16'hF000, 5'd21, 5'd31, 1'b0, 1'b0, 1'b1, 1'b0},
      '{16'hF000, 5'd10, 5'd20, 1'b0, 1'b0, 1'b0, 1'b0},
      '{16'hFFFF, 5'd9,  5'd3,  1'b0, 1'b0, 1'b1, 1'b0},
      '{16'hFFFF, 5'd0,  5'd31, 1'b1, 1'b0, 1'b0, 1'b1},
      '{16'hFFFF, 5'd6,  5'd19, 1'b1, 1'b1, 1'b1, 1'b1},
      '{16'hFFFF, 5'd0,  5'd31, 1'b1, 1'b1, 1'b0, 1'b0},
      '{16'h0FF7, 5'd0,  5'd31, 1'b0, 1'b1, 1'b1, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic copy_start = 1'b0, cmp_start = 1'b0;
   logic [W-1:0] cfg_chan_mask = '0;
   logic [AW-1:0] cfg_row_first = '0, cfg_row_last = '0;
   logic cfg_repeat = 1'b0, cfg_stop_on_equal = 1'b0;
   logic edit_wr_en = 1'b0;
   logic [AW-1:0] edit_row = '0;
   logic [W-1:0] edit_value = '0, edit_bit_en = '0;
   logic acq_rd_en;
   logic [AW-1:0] acq_rd_addr;
   logic [W-1:0] acq_rd_data = '0;
   logic busy, done, result_equal, diff_valid, diff_flag, stop_req;
   logic [AW-1:0] diff_row;

   logic [W-1:0] acq_mem [ROWS];
   logic [W-1:0] img_m [ROWS];
   int n_chk = 0, n_bad = 0, cyc = 0;

   always #10 clk = ~clk;

   acq_compare_engine #(.WIDTH(W), .MEM_ROWS(2 * ROWS)) dut (
      .clk(clk), .rst_n(rst_n), .copy_start(copy_start), .cmp_start(cmp_start),
      .cfg_chan_mask(cfg_chan_mask), .cfg_row_first(cfg_row_first),
      .cfg_row_last(cfg_row_last), .cfg_repeat(cfg_repeat),
      .cfg_stop_on_equal(cfg_stop_on_equal), .edit_wr_en(edit_wr_en),
      .edit_row(edit_row), .edit_value(edit_value), .edit_bit_en(edit_bit_en),
      .acq_rd_en(acq_rd_en), .acq_rd_addr(acq_rd_addr), .acq_rd_data(acq_rd_data),
      .busy(busy), .done(done), .result_equal(result_equal), .diff_valid(diff_valid),
      .diff_row(diff_row), .diff_flag(diff_flag), .stop_req(stop_req)
   );

   always @(posedge clk) if (acq_rd_en) acq_rd_data <= acq_mem[acq_rd_addr];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic run_copy();
      int k = 0;
      @(negedge clk) copy_start = 1'b1;
      @(negedge clk) copy_start = 1'b0;
      while (k < 200) begin
         @(negedge clk) k++;
         if (done) break;
      end
      check(k == ROWS + 1, "R1 copy done latency", k, ROWS + 1);
      for (int r = 0; r < ROWS; r++) img_m[r] = acq_mem[r];
   endtask

   task automatic edit(input int row, input logic [W-1:0] val, input logic [W-1:0] en,
                       input bit model);
      edit_wr_en = 1'b1; edit_row = AW'(row); edit_value = val; edit_bit_en = en;
      @(negedge clk) edit_wr_en = 1'b0;
      if (model) img_m[row] = (img_m[row] & ~en) | (val & en);
   endtask

   // poke >= 1: at that cycle fire a stray start, new range and edit while busy (R9, R2)
   task automatic run_cmp(input vec_t v, input int poke);
      int k = 0, seen = 0, n_rows, row_e, done_k = -1;
      bit flag_e;
      n_rows = (v.lo > v.hi) ? 0 : int'(v.hi) - int'(v.lo) + 1;
      cfg_chan_mask = v.mask; cfg_row_first = v.lo; cfg_row_last = v.hi;
      cfg_repeat = v.rep; cfg_stop_on_equal = v.steq; cmp_start = 1'b1;
      @(negedge clk) cmp_start = 1'b0;
      while (k < 200) begin
         @(negedge clk) k++;
         cmp_start = 1'b0; edit_wr_en = 1'b0;
         if (diff_valid) begin
            row_e  = int'(v.lo) + seen;
            flag_e = ((acq_mem[row_e % ROWS] ^ img_m[row_e % ROWS]) & v.mask) != 0;
            check(int'(diff_row) == row_e, "R4 row order", diff_row, row_e);
            check(diff_flag == flag_e, "R5 row flag (R3 mask)", diff_flag, flag_e);
            seen++;
         end
         if (stop_req && !done) check(0, "R8 stop outside done", 1, 0);
         if (done) begin done_k = k; break; end
         if (k == poke) begin
            cmp_start = 1'b1; cfg_row_first = 5'd31; cfg_row_last = 5'd31;
            edit_wr_en = 1'b1; edit_row = 5'd0; edit_value = '0; edit_bit_en = '1;
         end
      end
      check(done_k == n_rows + 1, (n_rows == 0) ? "R7 empty done latency" : "R6 done latency",
            done_k, n_rows + 1);
      check(seen == n_rows, "R4 rows reported", seen, n_rows);
      check(result_equal == v.exp_eq, "R6 result_equal", result_equal, v.exp_eq);
      check(stop_req == v.exp_stop, "R8 stop_req", stop_req, v.exp_stop);
      if (poke > 0) begin
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!done && !busy, "R9 stray start ignored", done, 0);
         end
      end
   endtask

   initial begin
      for (int r = 0; r < ROWS; r++) acq_mem[r] = W'((r * 16'h1357) ^ 16'hA5C3);
      repeat (3) @(negedge clk);
      check(!busy && !done && !stop_req && !diff_valid, "reset outputs idle", busy, 0);
      check(result_equal == 1'b1, "reset result_equal", result_equal, 1);
      rst_n = 1'b1;
      @(negedge clk);

      run_copy();
      // R1: freshly copied image equals the acquisition
      run_cmp('{16'hFFFF, 5'd0, 5'd31, 1'b0, 1'b0, 1'b1, 1'b0}, 0);

      // R2: partial bit edits while idle
      edit(5, ~acq_mem[5], 16'h0008, 1'b1);
      edit(20, ~acq_mem[20], 16'hF000, 1'b1);
      edit(7, ~acq_mem[7], 16'h0000, 1'b1);

      foreach (VECS[i]) run_cmp(VECS[i], 0);

      // R9 and R2: stray start and edit during a compare
      run_cmp(VECS[0], 3);
      run_cmp('{16'hFFFF, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0}, 0);

      // R2: edit row 0 while idle is applied
      edit(0, 16'h0001 ^ acq_mem[0], 16'h0001, 1'b1);
      run_cmp('{16'hFFFF, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0}, 0);

      // R1: recopy restores full equality
      run_copy();
      run_cmp('{16'hFFFF, 5'd0, 5'd31, 1'b1, 1'b1, 1'b1, 1'b1}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule